// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block merges the reset sources of a small processor into one held chip reset. The sources are a power-on pulse, a filtered active-low external reset pin and a watchdog timeout. The block sorts each event by whether the core is asleep, holds the reset through optional start-up delays, and keeps two cause flags that software reads after boot to find out why it restarted.

A watchdog timeout while the core sleeps is treated as a resumption of work. It raises a one-cycle wake request and does not reset the chip. Every other event sets a set/reset style reset register, which is asserted asynchronously on power-on and released synchronously to the main clock. Release can wait for two delays. The first is a power-up delay, counted on a separate internal RC clock. The second is an oscillator settle delay, counted on the main clock. Each delay counts to its full range and runs only when its enable is high.

Top module: `resetSequencer`

## Requirements
- R1: While `porPulse` is high, `chipRst` and `regResetEn` are high, and `toFlag` and `pdFlag` read 1.
- R2: `extRstN` held low for at least 4 consecutive `rcClk` rising edges causes one chip reset. A low pulse that covers at most 2 `rcClk` edges causes no reset and changes no flag.
- R3: Every power-on, pin reset and watchdog timeout while awake gives exactly one rising edge of `regResetEn`, which is a one-cycle pulse after power-on. `regResetEn` is never high while `chipRst` is low.
- R4: A watchdog timeout while `sleepActive` is high gives exactly one `wakeReq` pulse and clears `toFlag`. It causes no `chipRst` and no `regResetEn`.
- R5: With both delay enables low, `chipRst` from a synchronous event is high for exactly 1 `mainClk` cycle.
- R6: With only `oscDelayEn` high, `chipRst` is high for exactly 1025 `mainClk` cycles: one cycle to enter the delay, then 1024 counted cycles.
- R7: With `pwrDelayEn` high, release waits until 1024 `rcClk` cycles have been counted after the request crosses into the RC domain. If `oscDelayEn` is also high, 1024 main cycles follow the power-up delay.
- R8: A pin reset while awake leaves `toFlag` and `pdFlag` unchanged.
- R9: A pin reset while asleep resets the chip and leaves both flags unchanged.
- R10: A rising edge of `sleepActive` clears `pdFlag` on the next clock.
- R11: A watchdog timeout while awake resets the chip, clears `toFlag` and sets `pdFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mainClk | input | 1 | Main oscillator clock |
| rcClk | input | 1 | Separate internal RC clock for the filter and the power-up delay |
| porPulse | input | 1 | Power-on detect, active high, asynchronous |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| wdtTimeout | input | 1 | Watchdog timeout strobe, one `mainClk` cycle |
| sleepActive | input | 1 | Core is in sleep |
| pwrDelayEn | input | 1 | Enable for the power-up delay |
| oscDelayEn | input | 1 | Enable for the oscillator settle delay |
| chipRst | output | 1 | Held chip reset |
| regResetEn | output | 1 | One-cycle pulse telling the registers to load their reset state |
| wakeReq | output | 1 | One-cycle wake request from sleep |
| toFlag | output | 1 | Timeout cause flag, cleared by a watchdog timeout |
| pdFlag | output | 1 | Power-down cause flag, cleared on entry to sleep |

## Verification
The hardest cases to reach are the ones that depend on sleep history. A watchdog wake while asleep and a pin reset while asleep only mean something after a sleep entry has cleared `pdFlag`. The stimulus therefore runs one ordered story: power-on, pin resets while awake, sleep entry, pin reset while asleep, watchdog wake, then a watchdog reset while awake. The flag pair is compared after each step. The power-up delay crosses clock domains, so its length is checked against a window of main cycles derived from 1024 RC periods plus synchronizer latency. The oscillator delay is checked to the exact cycle.

// File: rtl/rstSeqPkg.sv
package rstSeqPkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PWR  = 2'd1,
    PH_OSC  = 2'd2
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic pwrRun;
    logic oscRun;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pinEvt;
    logic pwrDone;
    logic oscDone;
  } dpStatus_t;
endpackage

// File: rtl/rstSeqSync.sv
module rstSeqSync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstSeqDatapath.sv
module rstSeqDatapath
  import rstSeqPkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int FILT_LEN = 4,
  parameter int SYNC_STG = 2
) (
  input  logic       mainClk,
  input  logic       rcClk,
  input  logic       porPulse,
  input  logic       extRstN,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status,
  output logic       mainRstN
);
  localparam int              FILT_W  = $clog2(FILT_LEN + 1);
  localparam logic [FILT_W-1:0] FILT_TOP = FILT_W'(FILT_LEN);
  localparam logic [CNT_W-1:0]  CNT_TOP  = '1;

  logic porN;
  logic rcRstN;
  logic pinRc;
  logic pwrRunRc;
  logic pinRstRc;
  logic pinMain;
  logic pinMainD;
  logic pwrDoneRc;
  logic pwrDoneMain;
  logic [FILT_W-1:0] lowCnt;
  logic [CNT_W-1:0]  pwrCnt;
  logic [CNT_W-1:0]  oscCnt;

  assign porN = ~porPulse;

  // Reset synchronizers: asynchronous assert, synchronous release
  rstSeqSync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) rcRstSync_i (
    .clk(rcClk), .rstN(porN), .d(1'b1), .q(rcRstN));
  rstSeqSync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) mainRstSync_i (
    .clk(mainClk), .rstN(porN), .d(1'b1), .q(mainRstN));

  // Crossings
  rstSeqSync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) pinSync_i (
    .clk(rcClk), .rstN(rcRstN), .d(extRstN), .q(pinRc));
  rstSeqSync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) pwrRunSync_i (
    .clk(rcClk), .rstN(rcRstN), .d(strobe.pwrRun), .q(pwrRunRc));
  rstSeqSync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) pinBackSync_i (
    .clk(mainClk), .rstN(mainRstN), .d(pinRstRc), .q(pinMain));
  rstSeqSync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) pwrDoneSync_i (
    .clk(mainClk), .rstN(mainRstN), .d(pwrDoneRc), .q(pwrDoneMain));

  // Pin noise filter: consecutive low samples on the RC clock
  always_ff @(posedge rcClk or negedge rcRstN) begin
    if (!rcRstN)                lowCnt <= '0;
    else if (pinRc)             lowCnt <= '0;
    else if (lowCnt != FILT_TOP) lowCnt <= lowCnt + 1'b1;
  end
  assign pinRstRc = (lowCnt == FILT_TOP);

  // Power-up delay counter on the RC clock
  always_ff @(posedge rcClk or negedge rcRstN) begin
    if (!rcRstN) begin
      pwrCnt    <= '0;
      pwrDoneRc <= 1'b0;
    end else if (!pwrRunRc) begin
      pwrCnt    <= '0;
      pwrDoneRc <= 1'b0;
    end else if (!pwrDoneRc) begin
      if (pwrCnt == CNT_TOP) pwrDoneRc <= 1'b1;
      else                   pwrCnt    <= pwrCnt + 1'b1;
    end
  end

  // Oscillator settle counter on the main clock
  always_ff @(posedge mainClk or negedge mainRstN) begin
    if (!mainRstN) begin
      oscCnt   <= '0;
      pinMainD <= 1'b0;
    end else begin
      pinMainD <= pinMain;
      if (!strobe.oscRun)       oscCnt <= '0;
      else if (oscCnt != CNT_TOP) oscCnt <= oscCnt + 1'b1;
    end
  end

  assign status.pinEvt  = pinMain & ~pinMainD;
  assign status.pwrDone = pwrDoneMain;
  assign status.oscDone = strobe.oscRun && (oscCnt == CNT_TOP);
endmodule

// File: rtl/rstSeqControl.sv
module rstSeqControl
  import rstSeqPkg::*;
(
  input  logic       mainClk,
  input  logic       mainRstN,
  input  logic       wdtTimeout,
  input  logic       sleepActive,
  input  logic       pwrDelayEn,
  input  logic       oscDelayEn,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       chipRst,
  output logic       regResetEn,
  output logic       wakeReq,
  output logic       toFlag,
  output logic       pdFlag
);
  phase_t phase;
  phase_t phaseNxt;
  logic   chipNxt;
  logic   sleepD;
  logic   wdtAwake;
  logic   wdtAsleep;
  logic   rstEvt;

  assign wdtAwake  = wdtTimeout & ~sleepActive;
  assign wdtAsleep = wdtTimeout & sleepActive;
  assign rstEvt    = status.pinEvt | wdtAwake;

  assign strobe.pwrRun = (phase == PH_PWR) && pwrDelayEn;
  assign strobe.oscRun = (phase == PH_OSC);

  always_comb begin
    phaseNxt = phase;
    chipNxt  = chipRst;
    if (rstEvt) begin
      phaseNxt = PH_PWR;
      chipNxt  = 1'b1;
    end else begin
      case (phase)
        PH_PWR: begin
          if (!pwrDelayEn || status.pwrDone) begin
            if (oscDelayEn) phaseNxt = PH_OSC;
            else begin
              phaseNxt = PH_IDLE;
              chipNxt  = 1'b0;
            end
          end
        end
        PH_OSC: begin
          if (!oscDelayEn || status.oscDone) begin
            phaseNxt = PH_IDLE;
            chipNxt  = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge mainClk or negedge mainRstN) begin
    if (!mainRstN) begin
      phase      <= PH_PWR;
      chipRst    <= 1'b1;
      regResetEn <= 1'b1;
      wakeReq    <= 1'b0;
      toFlag     <= 1'b1;
      pdFlag     <= 1'b1;
      sleepD     <= 1'b0;
    end else begin
      phase      <= phaseNxt;
      chipRst    <= chipNxt;
      regResetEn <= rstEvt;
      wakeReq    <= wdtAsleep & ~status.pinEvt;
      sleepD     <= sleepActive;
      if (wdtTimeout) toFlag <= 1'b0;
      if (wdtAwake) pdFlag <= 1'b1;
      else if (sleepActive && !sleepD) pdFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/resetSequencer.sv
module resetSequencer
  import rstSeqPkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int FILT_LEN = 4,
  parameter int SYNC_STG = 2
) (
  input  logic mainClk,
  input  logic rcClk,
  input  logic porPulse,
  input  logic extRstN,
  input  logic wdtTimeout,
  input  logic sleepActive,
  input  logic pwrDelayEn,
  input  logic oscDelayEn,
  output logic chipRst,
  output logic regResetEn,
  output logic wakeReq,
  output logic toFlag,
  output logic pdFlag
);
  ctlStrobe_t strobe;
  dpStatus_t  status;
  logic       mainRstN;

  rstSeqDatapath #(.CNT_W(CNT_W), .FILT_LEN(FILT_LEN), .SYNC_STG(SYNC_STG)) dp_i (
    .mainClk(mainClk), .rcClk(rcClk), .porPulse(porPulse), .extRstN(extRstN),
    .strobe(strobe), .status(status), .mainRstN(mainRstN));

  rstSeqControl ctl_i (
    .mainClk(mainClk), .mainRstN(mainRstN), .wdtTimeout(wdtTimeout),
    .sleepActive(sleepActive), .pwrDelayEn(pwrDelayEn), .oscDelayEn(oscDelayEn),
    .status(status), .strobe(strobe), .chipRst(chipRst), .regResetEn(regResetEn),
    .wakeReq(wakeReq), .toFlag(toFlag), .pdFlag(pdFlag));
endmodule

// File: rtl/rstSeqChecker.sv
module rstSeqChecker (
  input logic mainClk,
  input logic porPulse,
  input logic sleepActive,
  input logic pwrDelayEn,
  input logic oscDelayEn,
  input logic chipRst,
  input logic regResetEn,
  input logic wakeReq,
  input logic toFlag,
  input logic pdFlag
);
  p_reg_needs_chip_r3: assert property (@(posedge mainClk) disable iff (porPulse)
    regResetEn |-> chipRst);

  p_wake_not_reg_r4: assert property (@(posedge mainClk) disable iff (porPulse)
    wakeReq |-> !regResetEn);

  p_wake_clears_to_r4: assert property (@(posedge mainClk) disable iff (porPulse)
    wakeReq |-> !toFlag);

  p_fast_release_r5: assert property (@(posedge mainClk) disable iff (porPulse)
    (!pwrDelayEn && !oscDelayEn && $past(regResetEn) && !regResetEn) |-> !chipRst);

  p_sleep_clears_pd_r10: assert property (@(posedge mainClk) disable iff (porPulse)
    $rose(sleepActive) |=> !pdFlag);
endmodule

bind resetSequencer rstSeqChecker chk_i (
  .mainClk(mainClk), .porPulse(porPulse), .sleepActive(sleepActive),
  .pwrDelayEn(pwrDelayEn), .oscDelayEn(oscDelayEn), .chipRst(chipRst),
  .regResetEn(regResetEn), .wakeReq(wakeReq), .toFlag(toFlag), .pdFlag(pdFlag));

// File: tb/resetSequencer_tb_top.sv
module resetSequencer_tb_top;
  logic mainClk = 1'b0;
  logic rcClk = 1'b0;
  logic porPulse = 1'b0;
  logic extRstN = 1'b1;
  logic wdtTimeout = 1'b0;
  logic sleepActive = 1'b0;
  logic pwrDelayEn = 1'b0;
  logic oscDelayEn = 1'b0;
  logic chipRst, regResetEn, wakeReq, toFlag, pdFlag;

  always #4 mainClk = ~mainClk;   // 125 MHz
  always #10 rcClk = ~rcClk;      // 50 MHz RC clock

  resetSequencer dut_i (
    .mainClk(mainClk), .rcClk(rcClk), .porPulse(porPulse), .extRstN(extRstN),
    .wdtTimeout(wdtTimeout), .sleepActive(sleepActive), .pwrDelayEn(pwrDelayEn),
    .oscDelayEn(oscDelayEn), .chipRst(chipRst), .regResetEn(regResetEn),
    .wakeReq(wakeReq), .toFlag(toFlag), .pdFlag(pdFlag));

  typedef struct {
    string req;
    string name;
    int expChip, expReg, expWake, expTo, expPd, expLvl, durMin, durMax;
    int bChip, bReg, bWake;
  } item_t;

  item_t sb[$];
  int tests = 0;
  int fails = 0;
  int chipRises = 0, regRises = 0, wakeCnt = 0, runLen = 0, lastLen = 0;
  bit prevChip = 0, prevReg = 0;
  int bChip = 0, bReg = 0, bWake = 0;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor and scoreboard compare
  always @(negedge mainClk) begin
    if (chipRst === 1'b1 && !prevChip) chipRises++;
    if (regResetEn === 1'b1 && !prevReg) regRises++;
    if (wakeReq === 1'b1) wakeCnt++;
    if (chipRst === 1'b1) runLen++;
    else if (runLen > 0) begin lastLen = runLen; runLen = 0; end
    prevChip = (chipRst === 1'b1);
    prevReg  = (regResetEn === 1'b1);
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.expChip >= 0) chk(it.req, {it.name, " chip resets"}, chipRises - it.bChip, it.expChip);
      if (it.expReg >= 0)  chk(it.req, {it.name, " register resets"}, regRises - it.bReg, it.expReg);
      if (it.expWake >= 0) chk(it.req, {it.name, " wakes"}, wakeCnt - it.bWake, it.expWake);
      if (it.expTo >= 0)   chk(it.req, {it.name, " toFlag"}, int'(toFlag === 1'b1), it.expTo);
      if (it.expPd >= 0)   chk(it.req, {it.name, " pdFlag"}, int'(pdFlag === 1'b1), it.expPd);
      if (it.expLvl >= 0)  chk(it.req, {it.name, " chipRst level"}, int'(chipRst === 1'b1), it.expLvl);
      if (it.durMin >= 0) begin
        tests++;
        if (lastLen < it.durMin || lastLen > it.durMax) begin
          fails++;
          $display("FAIL %s %s hold: actual %0d expected %0d..%0d", it.req, it.name,
                   lastLen, it.durMin, it.durMax);
        end
      end
    end
  end

  task automatic markBase();
    bChip = chipRises; bReg = regRises; bWake = wakeCnt;
  endtask

  task automatic push(string req, string name, int c, int r, int w, int t, int p,
                      int lvl, int dmin, int dmax);
    item_t it;
    it = '{req, name, c, r, w, t, p, lvl, dmin, dmax, bChip, bReg, bWake};
    @(negedge mainClk);
    sb.push_back(it);
    @(negedge mainClk);
    @(negedge mainClk);
  endtask

  task automatic pulseWdt();
    @(posedge mainClk); #1 wdtTimeout = 1'b1;
    @(posedge mainClk); #1 wdtTimeout = 1'b0;
  endtask

  task automatic pinLow(int ns);
    extRstN = 1'b0;
    #(ns);
    extRstN = 1'b1;
  endtask

  task automatic waitIdle();
    repeat (40) @(posedge mainClk);
    wait (chipRst === 1'b0);
    repeat (20) @(posedge mainClk);
  endtask

  bit finished = 0;

  initial begin
    // R1: power-on
    markBase();
    #1 porPulse = 1'b1;
    #100;
    push("R1", "power-on held", 1, 1, 0, 1, 1, 1, -1, -1);
    #3 porPulse = 1'b0;
    waitIdle();
    push("R5", "power-on released", -1, -1, -1, 1, 1, 0, -1, -1);

    // R2: short glitch ignored
    markBase();
    @(posedge rcClk); #3 pinLow(30);
    repeat (60) @(posedge mainClk);
    push("R2", "short pin glitch", 0, 0, 0, 1, 1, 0, -1, -1);

    // R2 R3 R8 R5: long pin low while awake
    markBase();
    pinLow(200);
    waitIdle();
    push("R8", "pin reset awake", 1, 1, 0, 1, 1, 0, 1, 1);

    // R10: sleep entry
    markBase();
    @(posedge mainClk); #1 sleepActive = 1'b1;
    repeat (4) @(posedge mainClk);
    push("R10", "sleep entry", 0, 0, 0, 1, 0, 0, -1, -1);

    // R9: pin reset while asleep
    markBase();
    pinLow(200);
    waitIdle();
    push("R9", "pin reset asleep", 1, 1, 0, 1, 0, 0, -1, -1);

    // R4: watchdog while asleep
    markBase();
    pulseWdt();
    repeat (10) @(posedge mainClk);
    push("R4", "watchdog wake", 0, 0, 1, 0, 0, 0, -1, -1);

    // R11 R3 R5: watchdog while awake
    @(posedge mainClk); #1 sleepActive = 1'b0;
    repeat (4) @(posedge mainClk);
    markBase();
    pulseWdt();
    waitIdle();
    push("R11", "watchdog reset awake", 1, 1, 0, 0, 1, 0, 1, 1);

    // R6: oscillator delay only
    oscDelayEn = 1'b1;
    markBase();
    pulseWdt();
    waitIdle();
    push("R6", "oscillator delay", 1, 1, 0, 0, 1, 0, 1025, 1025);

    // R7: power-up delay only
    oscDelayEn = 1'b0;
    pwrDelayEn = 1'b1;
    markBase();
    pulseWdt();
    waitIdle();
    push("R7", "power-up delay", 1, 1, 0, 0, 1, 0, 2560, 2600);

    // R7: both delays in sequence
    oscDelayEn = 1'b1;
    markBase();
    pulseWdt();
    waitIdle();
    push("R7", "both delays", 1, 1, 0, 0, 1, 0, 3584, 3630);

    // R1: power-on again restores flags
    pwrDelayEn = 1'b0;
    oscDelayEn = 1'b0;
    markBase();
    @(posedge mainClk); #2 porPulse = 1'b1;
    #60;
    push("R1", "second power-on", 1, 1, 0, 1, 1, 1, -1, -1);
    #3 porPulse = 1'b0;
    waitIdle();
    push("R3", "after second power-on", 1, 1, 0, 1, 1, 0, -1, -1);

    repeat (5) @(negedge mainClk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule